// File: doc/BRIEF.md
# Memory-Mapped Flash Read Sequencer

This block turns each read request from a memory-mapped port into a complete serial read transaction on a NOR flash. When a request is accepted, the sequencer pulls the selected chip select low, waits a programmable setup stretch, and then shifts out a read command byte and a 3- or 4-byte address. An optional run of dummy clocks follows, and then a fixed number of data bytes are shifted in. It holds the chip select for a programmable stretch after the last clock and finally releases it. The response port returns the assembled data word as a single-cycle pulse.

A small configuration port sets the timing and the target device. The 4-byte address mode is guarded by a separate unlock bit. A status read exposes the sequencer state. Software elsewhere on the chip may drive the same flash by hand. If it claims manual mode while an automatic read is still running, a sticky error is raised. That error can drive an interrupt.

The serial clock runs at half the core clock and idles low. Data leaves on the low phase and is sampled at the end of the high phase.

Top module: `spi_rd_seq`

## Requirements
- R1: After reset, every chip select is high, `spi_sck` is low, `req_ready` is 1, `irq` and `rsp_valid` are 0. The registers read: setup (offset 3) = 1, hold (offset 4) = 5, dummy (offset 0) = 0, error (offset 7) = 0, state (offset 9) = 0, idle flag (offset 10) = 1.
- R2: The command byte is 0x03 followed by address bits 23..0 when the address-width bit (offset 1, bit 0) is 0. It is 0x13 followed by all 32 address bits when that bit is 1. Every byte goes out most significant bit first on `spi_mosi`, and each bit is valid at the rising `spi_sck` edge.
- R3: A write to the address-width bit takes effect only while the unlock bit (offset 2, bit 0) is 1. At any other time the write is ignored.
- R4: The dummy count (offset 0, bits 3..0; 0 to 15) inserts exactly that many `spi_sck` pulses between the last address bit and the first data bit. A count of 0 skips the phase, so a transaction has 8 + address bits + dummy + 8·RD_BYTES rising edges in total.
- R5: The data is sampled on `spi_miso` during each high `spi_sck` phase and packed with the first bit received in the MSB of `rsp_data`. `rsp_valid` is high for exactly one cycle per transaction, in the cycle right after the last high `spi_sck` cycle.
- R6: The chip select is low for setup+2 clock cycles before the first high `spi_sck` cycle. Setup is offset 3, bits 2..0.
- R7: After the last high `spi_sck` cycle, the chip select stays low for hold+1 clock cycles and then rises. Hold is offset 4, bits 2..0.
- R8: The target bit (offset 5, bit 0) selects `spi_cs_n[0]` when 0 and `spi_cs_n[1]` when 1. Only the selected chip select ever goes low.
- R9: `req_ready` is 1 only while the sequencer is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.
- R10: Offset 9 reads the state code: 0 idle, 1 setup, 2 command, 3 address, 4 dummy, 5 data, 6 hold. Offset 10 bit 0 reads 1 exactly when the state is idle.
- R11: While the manual bit (offset 6, bit 0) is 1 during a transaction, the error bit (offset 7, bit 0) is set. It stays set until 1 is written to it, and the manual bit while idle never sets it. `irq` equals the error bit ANDed with the interrupt-enable bit (offset 8, bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 32 | Flash byte address |
| rsp_valid | output | 1 | One-cycle pulse, data ready |
| rsp_data | output | 8·RD_BYTES | Read data, first received bit in MSB |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| irq | output | 1 | Collision interrupt |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 2 | Active-low chip selects |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Each result has its own latency, and the bench samples every one of them on falling clock edges.

- **Request acceptance:** an accepted request moves the state to setup on that same rising edge. The state read, `req_ready` and the idle flag are therefore checked from the next falling edge onward.
- **Register writes:** a write lands on the following rising edge, so its readback is taken one falling edge later. The error bit lags the manual bit by one more register, so the collision is read two falling edges after the manual write.
- **Serial framing:** the chip-select setup and hold counts, the edge count, the captured command and address, and the response pulse are all measured by a flash model that counts cycles on falling edges. They are compared only after the chip select rises, against setup+2, hold+1 and the edge total derived from the vector.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam int ADDR_W = 32;
    localparam int NUM_CS = 2;

    localparam logic [7:0] CMD_RD3 = 8'h03;
    localparam logic [7:0] CMD_RD4 = 8'h13;

    localparam logic [3:0] REG_DUMMY  = 4'd0;
    localparam logic [3:0] REG_ADDR4  = 4'd1;
    localparam logic [3:0] REG_UNLOCK = 4'd2;
    localparam logic [3:0] REG_SETUP  = 4'd3;
    localparam logic [3:0] REG_HOLD   = 4'd4;
    localparam logic [3:0] REG_TARGET = 4'd5;
    localparam logic [3:0] REG_MANUAL = 4'd6;
    localparam logic [3:0] REG_ERR    = 4'd7;
    localparam logic [3:0] REG_IRQEN  = 4'd8;
    localparam logic [3:0] REG_STATE  = 4'd9;
    localparam logic [3:0] REG_IDLE   = 4'd10;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_CMD   = 3'd2,
        ST_ADDR  = 3'd3,
        ST_DUMMY = 3'd4,
        ST_DATA  = 3'd5,
        ST_HOLD  = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic [3:0] dummy;
        logic       addr4;
        logic [2:0] setup;
        logic [2:0] hold;
        logic       target;
    } seq_cfg_t;

endpackage

// File: rtl/spi_rd_cfg.sv
module spi_rd_cfg
    import spi_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [3:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic [2:0] state_i,
    input  logic       busy_i,
    output seq_cfg_t   cfg_o,
    output logic       irq_o
);

    typedef struct packed {
        logic [3:0] dummy;
        logic       addr4;
        logic       unlock;
        logic [2:0] setup;
        logic [2:0] hold;
        logic       target;
        logic       manual;
        logic       err;
        logic       irq_en;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (we_i) begin
            case (addr_i)
                REG_DUMMY:  d.dummy  = wdata_i[3:0];
                REG_ADDR4:  if (q.unlock) d.addr4 = wdata_i[0];
                REG_UNLOCK: d.unlock = wdata_i[0];
                REG_SETUP:  d.setup  = wdata_i[2:0];
                REG_HOLD:   d.hold   = wdata_i[2:0];
                REG_TARGET: d.target = wdata_i[0];
                REG_MANUAL: d.manual = wdata_i[0];
                REG_ERR:    if (wdata_i[0]) d.err = 1'b0;
                REG_IRQEN:  d.irq_en = wdata_i[0];
                default: ;
            endcase
        end
        if (q.manual && busy_i) d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.setup <= 3'd1;
            q.hold  <= 3'd5;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_DUMMY:  rdata_o[3:0] = q.dummy;
            REG_ADDR4:  rdata_o[0]   = q.addr4;
            REG_UNLOCK: rdata_o[0]   = q.unlock;
            REG_SETUP:  rdata_o[2:0] = q.setup;
            REG_HOLD:   rdata_o[2:0] = q.hold;
            REG_TARGET: rdata_o[0]   = q.target;
            REG_MANUAL: rdata_o[0]   = q.manual;
            REG_ERR:    rdata_o[0]   = q.err;
            REG_IRQEN:  rdata_o[0]   = q.irq_en;
            REG_STATE:  rdata_o[2:0] = state_i;
            REG_IDLE:   rdata_o[0]   = (state_i == 3'd0);
            default: ;
        endcase
    end

    assign cfg_o.dummy  = q.dummy;
    assign cfg_o.addr4  = q.addr4;
    assign cfg_o.setup  = q.setup;
    assign cfg_o.hold   = q.hold;
    assign cfg_o.target = q.target;
    assign irq_o        = q.err & q.irq_en;

    // R3
    addr4_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == REG_ADDR4 && !q.unlock) |=> $stable(cfg_o.addr4));

    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == REG_ERR && wdata_i[0] && !(q.manual && busy_i)) |=> !q.err);

    // R11
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.manual && busy_i) |=> q.err);

endmodule

// File: rtl/spi_rd_engine.sv
module spi_rd_engine
    import spi_rd_pkg::*;
#(
    parameter int RD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  seq_cfg_t                cfg_i,
    input  logic                    req_valid_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    output logic                    req_ready_o,
    output logic                    rsp_valid_o,
    output logic [RD_BYTES*8-1:0]   rsp_data_o,
    output logic [2:0]              state_o,
    output logic                    sck_o,
    output logic [NUM_CS-1:0]       cs_n_o,
    output logic                    mosi_o,
    input  logic                    miso_i
);

    localparam int DATA_BITS = RD_BYTES * 8;
    localparam int MAX_BITS  = (DATA_BITS > ADDR_W) ? DATA_BITS : ADDR_W;
    localparam int CNT_W     = $clog2(MAX_BITS);

    typedef struct packed {
        seq_state_e             st;
        logic                   ph;
        logic [CNT_W-1:0]       cnt;
        logic [2:0]             dly;
        logic [ADDR_W-1:0]      sr;
        logic [ADDR_W-1:0]      addr;
        logic [DATA_BITS-1:0]   rx;
        logic                   a4;
        logic [3:0]             dmy;
        logic [2:0]             hold;
        logic                   tgt;
        logic                   rsp_v;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.st   = ST_SETUP;
                    d.dly  = cfg_i.setup;
                    d.addr = req_addr_i;
                    d.a4   = cfg_i.addr4;
                    d.dmy  = cfg_i.dummy;
                    d.hold = cfg_i.hold;
                    d.tgt  = cfg_i.target;
                end
            end
            ST_SETUP: begin
                if (q.dly == 3'd0) begin
                    d.st  = ST_CMD;
                    d.ph  = 1'b0;
                    d.cnt = CNT_W'(7);
                    d.sr  = {(q.a4 ? CMD_RD4 : CMD_RD3), {(ADDR_W-8){1'b0}}};
                end else begin
                    d.dly = q.dly - 3'd1;
                end
            end
            ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA: begin
                d.ph = ~q.ph;
                if (q.ph) begin
                    d.sr = {q.sr[ADDR_W-2:0], 1'b0};
                    if (q.st == ST_DATA) d.rx = {q.rx[DATA_BITS-2:0], miso_i};
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end else begin
                        case (q.st)
                            ST_CMD: begin
                                d.st  = ST_ADDR;
                                d.sr  = q.a4 ? q.addr : {q.addr[ADDR_W-9:0], 8'h00};
                                d.cnt = q.a4 ? CNT_W'(ADDR_W-1) : CNT_W'(ADDR_W-9);
                            end
                            ST_ADDR: begin
                                if (q.dmy != 4'd0) begin
                                    d.st  = ST_DUMMY;
                                    d.cnt = CNT_W'(q.dmy) - CNT_W'(1);
                                end else begin
                                    d.st  = ST_DATA;
                                    d.cnt = CNT_W'(DATA_BITS-1);
                                end
                            end
                            ST_DUMMY: begin
                                d.st  = ST_DATA;
                                d.cnt = CNT_W'(DATA_BITS-1);
                            end
                            default: begin
                                d.st    = ST_HOLD;
                                d.dly   = q.hold;
                                d.rsp_v = 1'b1;
                            end
                        endcase
                    end
                end
            end
            ST_HOLD: begin
                if (q.dly == 3'd0) d.st = ST_IDLE;
                else               d.dly = q.dly - 3'd1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    logic shifting;
    assign shifting    = (q.st == ST_CMD) || (q.st == ST_ADDR) ||
                         (q.st == ST_DUMMY) || (q.st == ST_DATA);
    assign sck_o       = shifting && q.ph;
    assign mosi_o      = ((q.st == ST_CMD) || (q.st == ST_ADDR)) && q.sr[ADDR_W-1];
    assign req_ready_o = (q.st == ST_IDLE);
    assign rsp_valid_o = q.rsp_v;
    assign rsp_data_o  = q.rx;
    assign state_o     = q.st;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n_o[i] = !((q.st != ST_IDLE) && (q.tgt == 1'(i)));
    end

    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_o) <= 1);

    // R6
    sck_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> (cs_n_o != '1));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R5
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    // R7
    hold_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (cs_n_o != '1) && !sck_o);

endmodule

// File: rtl/spi_rd_seq.sv
module spi_rd_seq
    import spi_rd_pkg::*;
#(
    parameter int RD_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [31:0]           req_addr,
    output logic                  rsp_valid,
    output logic [RD_BYTES*8-1:0] rsp_data,
    input  logic                  cfg_we,
    input  logic [3:0]            cfg_addr,
    input  logic [7:0]            cfg_wdata,
    output logic [7:0]            cfg_rdata,
    output logic                  irq,
    output logic                  spi_sck,
    output logic [1:0]            spi_cs_n,
    output logic                  spi_mosi,
    input  logic                  spi_miso
);

    seq_cfg_t   cfg;
    logic [2:0] state;
    logic       busy;

    assign busy = (state != 3'd0);

    spi_rd_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .state_i (state),
        .busy_i  (busy),
        .cfg_o   (cfg),
        .irq_o   (irq)
    );

    spi_rd_engine #(.RD_BYTES(RD_BYTES)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg),
        .req_valid_i (req_valid),
        .req_addr_i  (req_addr),
        .req_ready_o (req_ready),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_data),
        .state_o     (state),
        .sck_o       (spi_sck),
        .cs_n_o      (spi_cs_n),
        .mosi_o      (spi_mosi),
        .miso_i      (spi_miso)
    );

endmodule

// File: tb/spi_rd_seq_tb_top.sv
`timescale 1ns/1ps
module spi_rd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        irq;
    logic        spi_sck;
    logic [1:0]  spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;

    always #2 clk = ~clk;

    spi_rd_seq #(.RD_BYTES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq(irq), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model and framing monitor
    int          aw_exp = 24;
    int          skip_exp = 32;
    logic [31:0] flash_data = '0;
    logic [7:0]  cap_cmd = '0;
    logic [31:0] cap_addr = '0;
    int n = 0, pre = 0, post = 0;
    int last_n = 0, last_pre = 0, last_post = 0;
    int txn_count = 0, rsp_cnt = 0;
    logic [31:0] rsp_last = '0;
    logic [1:0]  last_cs = 2'b11;
    logic active = 1'b0, seen = 1'b0, prev_sck = 1'b0;

    always @(negedge clk) begin
        if (rsp_valid) begin
            rsp_cnt++;
            rsp_last = rsp_data;
        end
        if (spi_cs_n == 2'b11) begin
            if (active) begin
                last_pre = pre; last_post = post; last_n = n;
                txn_count++;
                active = 1'b0;
            end
            pre = 0; post = 0; n = 0; seen = 1'b0; prev_sck = 1'b0;
        end else begin
            active  = 1'b1;
            last_cs = spi_cs_n;
            if (spi_sck) begin
                if (!prev_sck) begin
                    if (n < 8) cap_cmd = {cap_cmd[6:0], spi_mosi};
                    else if (n < 8 + aw_exp) cap_addr = {cap_addr[30:0], spi_mosi};
                    n++;
                end
                seen = 1'b1;
                post = 0;
            end else begin
                if (prev_sck) begin
                    if (n >= skip_exp && n < skip_exp + 32) spi_miso = flash_data[31 - (n - skip_exp)];
                    else spi_miso = 1'b0;
                end
                if (!seen) pre++;
                else post++;
            end
            prev_sck = spi_sck;
        end
    end

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1;
        v = cfg_rdata;
    endtask

    task automatic issue(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic        a4;
        logic [3:0]  dummy;
        logic [2:0]  setup;
        logic [2:0]  hold;
        logic        tgt;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'h00123456, 1'b0, 4'd8,  3'd1, 3'd5, 1'b0, 32'hA5C30F81},
        '{32'h89ABCDEF, 1'b1, 4'd0,  3'd0, 3'd0, 1'b1, 32'h12345678},
        '{32'h00FF00FF, 1'b0, 4'd15, 3'd7, 3'd7, 1'b0, 32'hFFFF0000},
        '{32'hDEADBEEF, 1'b1, 4'd1,  3'd3, 3'd2, 1'b1, 32'h0000FFFF},
        '{32'hC0FFEE01, 1'b0, 4'd0,  3'd2, 3'd6, 1'b1, 32'h5A5AC33C}
    };

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        int start, rs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cs_n", spi_cs_n, 2'b11);
        chk("R1 sck", spi_sck, 1'b0);
        chk("R1 ready", req_ready, 1'b1);
        chk("R1 irq", irq, 1'b0);
        chk("R1 rsp_valid", rsp_valid, 1'b0);
        cfg_read(4'd3, rv);  chk("R1 setup", rv, 8'd1);
        cfg_read(4'd4, rv);  chk("R1 hold", rv, 8'd5);
        cfg_read(4'd0, rv);  chk("R1 dummy", rv, 8'd0);
        cfg_read(4'd7, rv);  chk("R1 err", rv, 8'd0);
        cfg_read(4'd9, rv);  chk("R1 state", rv, 8'd0);
        cfg_read(4'd10, rv); chk("R1 idle", rv, 8'd1);

        // R3 address-width lock
        cfg_write(4'd1, 8'd1);
        cfg_read(4'd1, rv); chk("R3 locked write ignored", rv, 8'd0);
        cfg_write(4'd2, 8'd1);
        cfg_write(4'd1, 8'd1);
        cfg_read(4'd1, rv); chk("R3 unlocked write", rv, 8'd1);
        cfg_write(4'd1, 8'd0);
        cfg_write(4'd2, 8'd0);

        // vector table
        foreach (VECS[i]) begin
            cfg_write(4'd2, 8'd1);
            cfg_write(4'd1, {7'd0, VECS[i].a4});
            cfg_write(4'd2, 8'd0);
            cfg_write(4'd0, {4'd0, VECS[i].dummy});
            cfg_write(4'd3, {5'd0, VECS[i].setup});
            cfg_write(4'd4, {5'd0, VECS[i].hold});
            cfg_write(4'd5, {7'd0, VECS[i].tgt});
            aw_exp     = VECS[i].a4 ? 32 : 24;
            skip_exp   = 8 + aw_exp + int'(VECS[i].dummy);
            flash_data = VECS[i].data;
            start = txn_count; rs = rsp_cnt;
            issue(VECS[i].addr);
            while (txn_count == start) @(negedge clk);
            chk("R2 cmd", cap_cmd, VECS[i].a4 ? 8'h13 : 8'h03);
            chk("R2 addr", VECS[i].a4 ? cap_addr : {8'h00, cap_addr[23:0]},
                VECS[i].a4 ? VECS[i].addr : {8'h00, VECS[i].addr[23:0]});
            chk("R4 edge total", 64'(last_n), 64'(skip_exp + 32));
            chk("R5 data", rsp_last, VECS[i].data);
            chk("R5 one pulse", 64'(rsp_cnt - rs), 64'd1);
            chk("R6 setup", 64'(last_pre), 64'(int'(VECS[i].setup) + 2));
            chk("R7 hold", 64'(last_post), 64'(int'(VECS[i].hold) + 1));
            chk("R8 cs select", last_cs, VECS[i].tgt ? 2'b01 : 2'b10);
        end

        // R9 R10 R11 during a long transaction
        cfg_write(4'd2, 8'd1); cfg_write(4'd1, 8'd0); cfg_write(4'd2, 8'd0);
        cfg_write(4'd0, 8'd15); cfg_write(4'd3, 8'd7); cfg_write(4'd4, 8'd7);
        aw_exp = 24; skip_exp = 8 + 24 + 15;
        start = txn_count;
        issue(32'h00000040);
        chk("R9 ready low while busy", req_ready, 1'b0);
        cfg_read(4'd9, rv);  chk("R10 state setup", rv, 8'd1);
        cfg_read(4'd10, rv); chk("R10 idle low", rv, 8'd0);
        cfg_write(4'd6, 8'd1);
        @(negedge clk);
        cfg_read(4'd7, rv); chk("R11 collision sets err", rv, 8'd1);
        chk("R11 irq masked", irq, 1'b0);
        cfg_write(4'd8, 8'd1);
        chk("R11 irq enabled", irq, 1'b1);
        cfg_write(4'd6, 8'd0);
        cfg_read(4'd7, rv); chk("R11 err sticky", rv, 8'd1);
        cfg_write(4'd7, 8'd1);
        cfg_read(4'd7, rv); chk("R11 err cleared", rv, 8'd0);
        chk("R11 irq cleared", irq, 1'b0);
        while (txn_count == start) @(negedge clk);
        chk("R9 ready after idle", req_ready, 1'b1);
        cfg_read(4'd9, rv);  chk("R10 state idle", rv, 8'd0);
        cfg_read(4'd10, rv); chk("R10 idle high", rv, 8'd1);
        cfg_write(4'd6, 8'd1);
        repeat (3) @(negedge clk);
        cfg_read(4'd7, rv); chk("R11 manual while idle no err", rv, 8'd0);
        chk("R11 irq idle", irq, 1'b0);
        cfg_write(4'd6, 8'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule